// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block keeps a 32-bit position count for an incremental rotary or linear encoder. It runs on one system clock and brings the encoder signals (A, B, index, home) and an external gate input in through two-flop synchronizers. A run-time counter-control field picks the source of the count. The count can come from full quadrature decoding of A/B, from rising edges of A with B as the up/down line, from gated rising edges of A, or from a free-running internal timer with a power-of-two prescaler.

In the two encoder-driven control modes, a 3-bit initialization field decides what index, home, compare and modulo limits do to the count. The count can be cleared on every index, preloaded once on the next index, or preloaded on the first or second index after a home pulse. It can also be cleared on reaching a compare value, or wrapped between two bounds, with or without a clear on each index. Every setting arrives as a plain input port. A write strobe lets the surrounding logic overwrite the count at any time, including while counting is disabled.

Top module: `qenc_poscnt`

## Requirements
- R1: While `rst_n` is low and after its release, `pos` is 0, and no event has occurred until an input changes.
- R2: With `ctl_mode`=00, each single-bit step of the mapped `{A,B}` pair along 00→01→11→10→00 adds 1 to `pos` and each step in the reverse order subtracts 1. `dir_neg`=1 swaps the sign of both.
- R3: In quadrature mode, a change in which both mapped A and B flip in the same sampled cycle leaves `pos` unchanged.
- R4: While `en`=0, `pos` holds its value. Encoder, index, home, compare and timer activity have no effect on it.
- R5: A and B are inverted when `inv_a`/`inv_b` is 1 and then exchanged when `swap_ab` is 1. Both decoding and index qualification use these mapped values. `match_ab[1]` compares with mapped A and `match_ab[0]` with mapped B.
- R6: With `ctl_mode`=01, each rising edge of mapped A changes `pos` by one step: down when mapped B is 1 and up when it is 0.
- R7: With `ctl_mode`=10, a rising edge of mapped A counts only while `ext_gate` is 1, in the direction `dir_neg` gives (0 up, 1 down). With `gate_en`=1, counting in any control mode advances only while `ext_gate` is 1.
- R8: With `ctl_mode`=11, `pos` steps once every 2^`prescale` clock cycles in the direction given by `dir_neg`. When `ctl_mode` is 10 or 11, `init_mode` has no effect.
- R9: An index event is a rising edge of the synchronized `enc_idx`. In quadrature mode it counts only if mapped `{A,B}` equals `match_ab`; in mode 01 every rising edge counts. With `init_mode`=001 an index event clears `pos`; with 000 it does nothing.
- R10: `init_mode` 010 loads `init_val` on the first index event only. Mode 011 loads it on the first index event after a home rising edge. Mode 100 loads it on the second index event after a home rising edge. Each of these loads once, and a change of `init_mode` re-arms it. A home edge in the same cycle as an index takes precedence.
- R11: With `init_mode`=101, `pos` becomes 0 on the cycle after it equals `cmp_val`.
- R12: With `init_mode`=110, an up step from `mod_hi` gives `mod_lo` and a down step from `mod_lo` gives `mod_hi`. Mode 111 does the same and also clears `pos` on each index event.
- R13: `cnt_wr`=1 loads `cnt_wr_data` into `pos` on that clock edge, whatever the other inputs are and whether or not `en` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Counting enable |
| ctl_mode | input | 2 | Count source: 00 quadrature, 01 clock+direction, 10 gated clock, 11 timer |
| init_mode | input | 3 | Index/home/compare/modulo policy |
| match_ab | input | 2 | Mapped {A,B} value that qualifies an index |
| prescale | input | 3 | Timer division exponent (1:2^n) |
| dir_neg | input | 1 | Invert or set default count direction |
| gate_en | input | 1 | Let `ext_gate` gate counting in every mode |
| swap_ab | input | 1 | Exchange A and B after polarity |
| inv_a | input | 1 | Invert the A input |
| inv_b | input | 1 | Invert the B input |
| init_val | input | 32 | Preload value for one-shot modes |
| cmp_val | input | 32 | Compare-clear value |
| mod_lo | input | 32 | Modulo lower bound |
| mod_hi | input | 32 | Modulo upper bound |
| cnt_wr | input | 1 | Overwrite strobe for the count |
| cnt_wr_data | input | 32 | Value written by `cnt_wr` |
| enc_a | input | 1 | Encoder A / external clock |
| enc_b | input | 1 | Encoder B / external direction |
| enc_idx | input | 1 | Encoder index |
| enc_home | input | 1 | Home switch |
| ext_gate | input | 1 | External count gate |
| pos | output | 32 | Position count |

## Verification
The hardest state to reach from the ports is the second-index preload. It needs a home edge, a first qualified index that must leave the count alone, and then a second qualified index, all with the one-shot still armed. The stimulus holds A/B at the match value so that no count steps interfere, presets the count with the write strobe, and pulses home and index in turn. Re-arming is forced by moving `init_mode` away and back. Modulo wrap and compare clear are reached by presetting the count next to the boundary and taking one Gray step.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    typedef enum logic [1:0] {
        CM_QUAD    = 2'b00,
        CM_EXTDIR  = 2'b01,
        CM_EXTGATE = 2'b10,
        CM_TIMER   = 2'b11
    } ctl_mode_e;

    typedef enum logic [2:0] {
        IM_NONE        = 3'b000,
        IM_IDX_CLR     = 3'b001,
        IM_NEXT_LOAD   = 3'b010,
        IM_HOME1_LOAD  = 3'b011,
        IM_HOME2_LOAD  = 3'b100,
        IM_CMP_CLR     = 3'b101,
        IM_MOD         = 3'b110,
        IM_MOD_IDX_CLR = 3'b111
    } init_mode_e;

    // Maximum timer division exponent is 7, so the prescaler needs 7 bits.
    localparam int unsigned PRE_W = 7;

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
    parameter int unsigned WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    typedef struct packed {
        logic [WIDTH-1:0] st1;
        logic [WIDTH-1:0] st2;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.st1 = din;
        s_d.st2 = s_q.st1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dout = s_q.st2;
endmodule

// File: rtl/qenc_decode.sv
module qenc_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic a_s,
    input  logic b_s,
    input  logic inv_a,
    input  logic inv_b,
    input  logic swap_ab,
    output logic a_m,
    output logic b_m,
    output logic q_up,
    output logic q_dn,
    output logic a_rise
);
    typedef struct packed {
        logic [1:0] ab_prev;
    } dec_t;

    dec_t d_d, d_q;
    logic a_pol, b_pol;
    logic [1:0] diff;

    // Position of a {A,B} code along the forward Gray cycle.
    function automatic logic [1:0] gray_pos(input logic [1:0] ab);
        case (ab)
            2'b00:   gray_pos = 2'd0;
            2'b01:   gray_pos = 2'd1;
            2'b11:   gray_pos = 2'd2;
            default: gray_pos = 2'd3;
        endcase
    endfunction

    always_comb begin
        a_pol = a_s ^ inv_a;
        b_pol = b_s ^ inv_b;
        a_m   = swap_ab ? b_pol : a_pol;
        b_m   = swap_ab ? a_pol : b_pol;

        diff   = gray_pos({a_m, b_m}) - gray_pos(d_q.ab_prev);
        q_up   = (diff == 2'd1);
        q_dn   = (diff == 2'd3);
        a_rise = a_m & ~d_q.ab_prev[1];

        d_d         = d_q;
        d_d.ab_prev = {a_m, b_m};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end
endmodule

// File: rtl/qenc_stepgen.sv
module qenc_stepgen
    import qenc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] ctl_mode,
    input  logic [2:0] prescale,
    input  logic       dir_neg,
    input  logic       gate_en,
    input  logic       gate_s,
    input  logic       a_rise,
    input  logic       b_m,
    input  logic       q_up,
    input  logic       q_dn,
    output logic       step_up,
    output logic       step_dn
);
    typedef struct packed {
        logic [PRE_W-1:0] div_cnt;
    } pre_t;

    pre_t p_d, p_q;
    ctl_mode_e  cm;
    logic       gate_ok;
    logic       run_tmr;
    logic       tmr_tick;
    logic [PRE_W-1:0] limit;
    logic       raw_up, raw_dn;

    always_comb begin
        cm      = ctl_mode_e'(ctl_mode);
        gate_ok = !(gate_en || cm == CM_EXTGATE) || gate_s;
        run_tmr = en && (cm == CM_TIMER) && gate_ok;
        limit   = PRE_W'((8'd1 << prescale) - 8'd1);
        tmr_tick = run_tmr && (p_q.div_cnt >= limit);

        p_d = p_q;
        if (run_tmr) begin
            if (tmr_tick) p_d.div_cnt = '0;
            else          p_d.div_cnt = p_q.div_cnt + PRE_W'(1);
        end

        raw_up = 1'b0;
        raw_dn = 1'b0;
        case (cm)
            CM_QUAD: begin
                raw_up = dir_neg ? q_dn : q_up;
                raw_dn = dir_neg ? q_up : q_dn;
            end
            CM_EXTDIR: begin
                raw_up = a_rise & ~b_m;
                raw_dn = a_rise &  b_m;
            end
            CM_EXTGATE: begin
                raw_up = a_rise & ~dir_neg;
                raw_dn = a_rise &  dir_neg;
            end
            default: begin
                raw_up = tmr_tick & ~dir_neg;
                raw_dn = tmr_tick &  dir_neg;
            end
        endcase

        step_up = raw_up && en && gate_ok;
        step_dn = raw_dn && en && gate_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end
endmodule

// File: rtl/qenc_poscnt.sv
module qenc_poscnt
    import qenc_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [1:0]       ctl_mode,
    input  logic [2:0]       init_mode,
    input  logic [1:0]       match_ab,
    input  logic [2:0]       prescale,
    input  logic             dir_neg,
    input  logic             gate_en,
    input  logic             swap_ab,
    input  logic             inv_a,
    input  logic             inv_b,
    input  logic [CNT_W-1:0] init_val,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic [CNT_W-1:0] mod_lo,
    input  logic [CNT_W-1:0] mod_hi,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wr_data,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic             enc_idx,
    input  logic             enc_home,
    input  logic             ext_gate,
    output logic [CNT_W-1:0] pos
);
    localparam int unsigned SYNC_W = 5;

    typedef struct packed {
        logic [CNT_W-1:0] pos;
        logic             idx_prev;
        logic             home_prev;
        logic [2:0]       mode_prev;
        logic             armed;
        logic             home_seen;
        logic             idx_once;
    } st_t;

    st_t s_d, s_q;

    logic a_s, b_s, idx_s, home_s, gate_s;
    logic a_m, b_m, q_up, q_dn, a_rise;
    logic step_up, step_dn;
    logic idx_evt, home_evt, policy_on;
    ctl_mode_e  cm;
    init_mode_e im;
    logic [CNT_W-1:0] stepped;

    qenc_sync #(.WIDTH(SYNC_W)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({enc_a, enc_b, enc_idx, enc_home, ext_gate}),
        .dout ({a_s, b_s, idx_s, home_s, gate_s})
    );

    qenc_decode u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_s    (a_s),
        .b_s    (b_s),
        .inv_a  (inv_a),
        .inv_b  (inv_b),
        .swap_ab(swap_ab),
        .a_m    (a_m),
        .b_m    (b_m),
        .q_up   (q_up),
        .q_dn   (q_dn),
        .a_rise (a_rise)
    );

    qenc_stepgen u_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .ctl_mode(ctl_mode),
        .prescale(prescale),
        .dir_neg (dir_neg),
        .gate_en (gate_en),
        .gate_s  (gate_s),
        .a_rise  (a_rise),
        .b_m     (b_m),
        .q_up    (q_up),
        .q_dn    (q_dn),
        .step_up (step_up),
        .step_dn (step_dn)
    );

    always_comb begin
        cm = ctl_mode_e'(ctl_mode);
        im = init_mode_e'(init_mode);
        policy_on = en && (cm == CM_QUAD || cm == CM_EXTDIR);

        idx_evt  = policy_on && idx_s && !s_q.idx_prev &&
                   ((cm == CM_EXTDIR) || ({a_m, b_m} == match_ab));
        home_evt = policy_on && home_s && !s_q.home_prev;

        if (step_up)      stepped = s_q.pos + CNT_W'(1);
        else if (step_dn) stepped = s_q.pos - CNT_W'(1);
        else              stepped = s_q.pos;

        s_d           = s_q;
        s_d.idx_prev  = idx_s;
        s_d.home_prev = home_s;
        s_d.mode_prev = init_mode;
        s_d.pos       = stepped;

        if (policy_on) begin
            case (im)
                IM_IDX_CLR: begin
                    if (idx_evt) s_d.pos = '0;
                end
                IM_NEXT_LOAD: begin
                    if (idx_evt && s_q.armed) begin
                        s_d.pos   = init_val;
                        s_d.armed = 1'b0;
                    end
                end
                IM_HOME1_LOAD: begin
                    if (home_evt) begin
                        s_d.home_seen = 1'b1;
                    end else if (idx_evt && s_q.armed && s_q.home_seen) begin
                        s_d.pos   = init_val;
                        s_d.armed = 1'b0;
                    end
                end
                IM_HOME2_LOAD: begin
                    if (home_evt) begin
                        s_d.home_seen = 1'b1;
                        s_d.idx_once  = 1'b0;
                    end else if (idx_evt && s_q.armed && s_q.home_seen) begin
                        if (s_q.idx_once) begin
                            s_d.pos   = init_val;
                            s_d.armed = 1'b0;
                        end else begin
                            s_d.idx_once = 1'b1;
                        end
                    end
                end
                IM_CMP_CLR: begin
                    if (s_q.pos == cmp_val) s_d.pos = '0;
                end
                IM_MOD, IM_MOD_IDX_CLR: begin
                    if (step_up && s_q.pos == mod_hi) s_d.pos = mod_lo;
                    if (step_dn && s_q.pos == mod_lo) s_d.pos = mod_hi;
                    if (im == IM_MOD_IDX_CLR && idx_evt) s_d.pos = '0;
                end
                default: ;
            endcase
        end

        if (init_mode != s_q.mode_prev) begin
            s_d.armed     = 1'b1;
            s_d.home_seen = 1'b0;
            s_d.idx_once  = 1'b0;
        end

        if (cnt_wr) s_d.pos = cnt_wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.armed <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign pos = s_q.pos;
endmodule

// File: rtl/qenc_poscnt_chk.sv
module qenc_poscnt_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [1:0]       ctl_mode,
    input logic [2:0]       init_mode,
    input logic [CNT_W-1:0] cmp_val,
    input logic [CNT_W-1:0] mod_lo,
    input logic [CNT_W-1:0] mod_hi,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] cnt_wr_data,
    input logic             step_up,
    input logic             step_dn,
    input logic [CNT_W-1:0] pos
);
    // R4: disabled counter holds
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !cnt_wr) |=> (pos == $past(pos)));

    // R13: overwrite strobe wins
    a_r13_write: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (pos == $past(cnt_wr_data)));

    // R11: compare clear
    a_r11_cmp_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !ctl_mode[1] && init_mode == 3'b101 && !cnt_wr && pos == cmp_val)
        |=> (pos == '0));

    // R12: modulo wrap upward
    a_r12_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !ctl_mode[1] && init_mode == 3'b110 && !cnt_wr && step_up && pos == mod_hi)
        |=> (pos == $past(mod_lo)));

    // R2: never both directions at once
    a_r2_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_up && step_dn));

    // R8: timer and gated modes move by at most one per cycle
    a_r8_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ctl_mode[1] && !cnt_wr) |=>
        (pos == $past(pos) || pos == $past(pos) + CNT_W'(1) || pos == $past(pos) - CNT_W'(1)));
endmodule

bind qenc_poscnt qenc_poscnt_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .ctl_mode   (ctl_mode),
    .init_mode  (init_mode),
    .cmp_val    (cmp_val),
    .mod_lo     (mod_lo),
    .mod_hi     (mod_hi),
    .cnt_wr     (cnt_wr),
    .cnt_wr_data(cnt_wr_data),
    .step_up    (step_up),
    .step_dn    (step_dn),
    .pos        (pos)
);

// File: tb/qenc_poscnt_test.sv
`timescale 1ns/1ps
module qenc_poscnt_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b1;
    logic [1:0]  ctl_mode = 2'b00;
    logic [2:0]  init_mode = 3'b000;
    logic [1:0]  match_ab = 2'b00;
    logic [2:0]  prescale = 3'd0;
    logic        dir_neg = 1'b0, gate_en = 1'b0, swap_ab = 1'b0;
    logic        inv_a = 1'b0, inv_b = 1'b0;
    logic [31:0] init_val = 32'd777, cmp_val = 32'd40;
    logic [31:0] mod_lo = 32'd10, mod_hi = 32'd13;
    logic        cnt_wr = 1'b0;
    logic [31:0] cnt_wr_data = '0;
    logic        enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0, enc_home = 1'b0, ext_gate = 1'b0;
    logic [31:0] pos;

    int n_chk = 0;
    int n_err = 0;
    int ab_p = 0;

    qenc_poscnt uut (.*);

    always #4 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        tick(5);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    function automatic logic [1:0] code(input int p);
        case (p)
            0: code = 2'b00;
            1: code = 2'b01;
            2: code = 2'b11;
            default: code = 2'b10;
        endcase
    endfunction

    task automatic q_up();
        ab_p = (ab_p + 1) % 4;
        {enc_a, enc_b} = code(ab_p);
        settle();
    endtask

    task automatic q_dn();
        ab_p = (ab_p + 3) % 4;
        {enc_a, enc_b} = code(ab_p);
        settle();
    endtask

    task automatic wr(input logic [31:0] v);
        cnt_wr = 1'b1;
        cnt_wr_data = v;
        tick(1);
        cnt_wr = 1'b0;
    endtask

    task automatic pulse_idx();
        enc_idx = 1'b1; tick(3); enc_idx = 1'b0; settle();
    endtask

    task automatic pulse_home();
        enc_home = 1'b1; tick(3); enc_home = 1'b0; settle();
    endtask

    task automatic pulse_a();
        enc_a = 1'b1; settle(); enc_a = 1'b0; settle();
    endtask

    task automatic t_reset();
        tick(3);
        check("R1 in reset", pos, 32'd0);
        rst_n = 1'b1;
        settle();
        check("R1 after reset", pos, 32'd0);
    endtask

    task automatic t_quad();
        repeat (4) q_up();
        check("R2 four up steps", pos, 32'd4);
        repeat (2) q_dn();
        check("R2 two down steps", pos, 32'd2);
        dir_neg = 1'b1;
        q_up();
        check("R2 dir_neg inverts", pos, 32'd1);
        dir_neg = 1'b0;
        ab_p = (ab_p + 2) % 4;
        {enc_a, enc_b} = code(ab_p);
        settle();
        check("R3 illegal jump ignored", pos, 32'd1);
    endtask

    task automatic t_disable();
        en = 1'b0;
        q_up();
        check("R4 step while disabled", pos, 32'd1);
        wr(32'd1000);
        check("R13 write while disabled", pos, 32'd1000);
        en = 1'b1;
        settle();
        check("R4 no catch-up on enable", pos, 32'd1000);
        q_up();
        check("R2 count after enable", pos, 32'd1001);
    endtask

    task automatic t_index();
        while (ab_p != 0) q_up();
        init_mode = 3'b001;
        settle();
        wr(32'd50);
        match_ab = 2'b01;
        settle();
        pulse_idx();
        check("R9 unqualified index", pos, 32'd50);
        match_ab = 2'b00;
        settle();
        pulse_idx();
        check("R9 qualified index clears", pos, 32'd0);
        init_mode = 3'b000;
        settle();
        wr(32'd50);
        pulse_idx();
        check("R9 mode 000 no effect", pos, 32'd50);
    endtask

    task automatic t_map();
        inv_a = 1'b1;
        settle();
        wr(32'd20);
        match_ab = 2'b10;
        init_mode = 3'b001;
        settle();
        pulse_idx();
        check("R5 polarity applied to match", pos, 32'd0);
        init_mode = 3'b000;
        match_ab = 2'b00;
        inv_a = 1'b0;
        settle();
        swap_ab = 1'b1;
        settle();
        wr(32'd30);
        q_up();
        check("R5 swap reverses direction", pos, 32'd29);
        q_dn();
        swap_ab = 1'b0;
        settle();
    endtask

    task automatic t_oneshot();
        init_mode = 3'b010;
        settle();
        wr(32'd5);
        pulse_idx();
        check("R10 next-index load", pos, 32'd777);
        wr(32'd5);
        pulse_idx();
        check("R10 loads only once", pos, 32'd5);
        init_mode = 3'b000; settle();
        init_mode = 3'b010; settle();
        pulse_idx();
        check("R10 re-armed by mode change", pos, 32'd777);

        init_mode = 3'b011;
        settle();
        wr(32'd5);
        pulse_idx();
        check("R10 index before home ignored", pos, 32'd5);
        pulse_home();
        pulse_idx();
        check("R10 first index after home loads", pos, 32'd777);
        wr(32'd5);
        pulse_idx();
        check("R10 first-after-home once", pos, 32'd5);

        init_mode = 3'b100;
        settle();
        wr(32'd5);
        pulse_home();
        pulse_idx();
        check("R10 first index after home skipped", pos, 32'd5);
        pulse_idx();
        check("R10 second index after home loads", pos, 32'd777);
    endtask

    task automatic t_cmp_mod();
        init_mode = 3'b101;
        settle();
        wr(32'd39);
        q_up();
        check("R11 compare clear", pos, 32'd0);

        init_mode = 3'b110;
        settle();
        wr(32'd13);
        q_up();
        check("R12 wrap up to low bound", pos, 32'd10);
        q_dn();
        check("R12 wrap down to high bound", pos, 32'd13);
        q_up();
        q_up();
        check("R12 normal step inside range", pos, 32'd11);
        init_mode = 3'b111;
        match_ab = code(ab_p);
        settle();
        pulse_idx();
        check("R12 modulo index clear", pos, 32'd0);
        init_mode = 3'b000;
        while (ab_p != 0) q_up();
        match_ab = 2'b00;
        settle();
    endtask

    task automatic t_ext();
        ctl_mode = 2'b01;
        settle();
        wr(32'd100);
        pulse_a();
        check("R6 A edge with B low counts up", pos, 32'd101);
        enc_b = 1'b1; settle();
        pulse_a();
        check("R6 A edge with B high counts down", pos, 32'd100);
        enc_b = 1'b0; settle();
        init_mode = 3'b001;
        match_ab = 2'b11;
        settle();
        pulse_idx();
        check("R9 mode 01 index needs no match", pos, 32'd0);
        init_mode = 3'b000;
        match_ab = 2'b00;
        wr(32'd100);
        gate_en = 1'b1;
        ext_gate = 1'b0;
        settle();
        pulse_a();
        check("R7 gate_en blocks mode 01", pos, 32'd100);
        gate_en = 1'b0;
        settle();

        ctl_mode = 2'b10;
        settle();
        wr(32'd0);
        pulse_a();
        check("R7 gate low blocks count", pos, 32'd0);
        init_mode = 3'b001;
        settle();
        wr(32'd9);
        pulse_idx();
        check("R8 init_mode ignored in mode 10", pos, 32'd9);
        init_mode = 3'b000;
        wr(32'd0);
        ext_gate = 1'b1; settle();
        pulse_a();
        check("R7 gate high counts", pos, 32'd1);
        dir_neg = 1'b1; settle();
        pulse_a();
        check("R7 dir_neg counts down", pos, 32'd0);
        dir_neg = 1'b0;
        ext_gate = 1'b0;
        settle();
    endtask

    task automatic t_timer();
        logic [31:0] p0;
        ctl_mode = 2'b11;
        prescale = 3'd0;
        settle();
        p0 = pos; tick(20);
        check("R8 timer 1:1", pos - p0, 32'd20);
        prescale = 3'd2;
        settle();
        p0 = pos; tick(40);
        check("R8 timer 1:4", pos - p0, 32'd10);
        prescale = 3'd7;
        settle();
        p0 = pos; tick(256);
        check("R8 timer 1:128", pos - p0, 32'd2);
        prescale = 3'd0;
        dir_neg = 1'b1;
        settle();
        p0 = pos; tick(10);
        check("R8 timer down", p0 - pos, 32'd10);
        dir_neg = 1'b0;
        gate_en = 1'b1;
        settle();
        p0 = pos; tick(10);
        check("R7 gate_en stops timer", pos, p0);
        wr(32'd7);
        check("R13 write in timer mode", pos, 32'd7);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_quad();
        t_disable();
        t_index();
        t_map();
        t_oneshot();
        t_cmp_mod();
        t_ext();
        t_timer();
        report();
    end
endmodule